// File: doc/BRIEF.md
# Cache Way Lookup Table

This block is a small, fully associative table that sits in front of a set-associative data cache. It remembers which cache way held each recently used cache line. Before a cache access, the requester presents the byte address. If a filled entry holds the same line address, the table answers in the same cycle with a hit and the way number. The cache can then enable just that one way for both its tag and data arrays. On a miss, the cache does a normal all-way access.

When the cache misses, or the table misses while the cache hits, the controller claims an entry straight away with the allocate port. The entry then waits in a pending state. Once the controller knows which way holds the line, it writes that way through the fill port. Slots for new lines are handed out in strict rotation by a wrapping counter, so the oldest line is the one that is overwritten.

Entries are never invalidated when the cache evicts a line. A stale entry only sends the access to a way that no longer holds the line, and that access ends in an ordinary cache miss. The allocation that follows rewrites the entry.

Top module: `way_finder`

## Requirements
- R1: While an entry is valid and its stored line address equals the lookup line address, `lk_hit` is 1 and `lk_way` carries that entry's way in the same cycle, combinationally from the stored state.
- R2: The line address is `lk_addr[ADDR_W-1:LINE_OFF]` (bits 31:5 by default), and the same slice is taken from `alloc_addr`. The low `LINE_OFF` offset bits have no effect on any match.
- R3: When no valid entry matches, `lk_hit` is 0 and `lk_way` is all zeros.
- R4: An allocated entry is pending and does not hit until its way has been filled. This holds even if it previously held a valid way for the same line.
- R5: On a fill (`fill_en` high at a clock edge), the pending entry takes `fill_way` and becomes valid from the next cycle. A fill when no entry is pending changes no lookup result.
- R6: Allocating a line address that already has a valid or pending entry reuses that entry. No second slot is taken and the rotation counter does not move.
- R7: Allocating a new line address writes the slot the rotation counter points at, and the counter then advances modulo DEPTH. With DEPTH=16, the seventeenth new line displaces the first one, and the other lines keep their ways.
- R8: At most one valid entry ever matches a given line address.
- R9: A synchronous active-low reset makes every entry neither valid nor pending and sets the rotation counter to slot 0.
- R10: Only the most recent allocation stays pending. A second allocation before a fill abandons the earlier entry, which then never hits, and the next fill goes to the newer entry. When a fill and an allocation fall in the same cycle, the fill completes the entry that was already pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_addr | input | ADDR_W | Byte address searched by the lookup |
| lk_hit | output | 1 | A filled entry matches the lookup line |
| lk_way | output | WAY_W | Way of the matching entry, zero on a miss |
| alloc_en | input | 1 | Claim an entry for `alloc_addr` at this edge |
| alloc_addr | input | ADDR_W | Byte address whose line is being allocated |
| fill_en | input | 1 | Write `fill_way` into the pending entry at this edge |
| fill_way | input | WAY_W | Way resolved by the cache controller |

## Verification
The assertions take for granted that `alloc_en` and `fill_en` are known (never X or Z) at every clock edge after reset. They also rely on the controller holding at most one outstanding allocation at a time, which is the way the block is meant to be driven. The bench changes these inputs only on falling edges, and it issues each allocation either alone or followed by its own fill. The one exception is a deliberate double allocation that exercises the abandon rule. Lookups are driven only while allocate and fill are idle, so every lookup observes settled table state.

// File: rtl/wf_pkg.sv
// Package: shared helpers for the way lookup table.
// Assumes: counts are small (at most a few hundred slots).
package wf_pkg;
    localparam int unsigned WF_MAX_DEPTH = 64;

    // Next slot index in a ring of n slots.
    function automatic int unsigned ring_next(input int unsigned cur, input int unsigned n);
        return (cur + 1 >= n) ? 0 : cur + 1;
    endfunction
endpackage

// File: rtl/wf_slot.sv
// Module: one table entry holding a line tag, a way number and the
// valid / pending flags.
// Assumes: take_tag and take_way may both be high; take_tag wins.
module wf_slot #(
    parameter int TAG_W = 27,
    parameter int WAY_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_tag,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             take_way,
    input  logic [WAY_W-1:0] new_way,
    input  logic             drop_pend,
    output logic [TAG_W-1:0] tag_q,
    output logic [WAY_W-1:0] way_q,
    output logic             valid_q,
    output logic             pend_q
);
    // Entry state update: claim, fill, or abandon the pending state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tag_q   <= '0;
            way_q   <= '0;
            valid_q <= 1'b0;
            pend_q  <= 1'b0;
        end else if (take_tag) begin
            tag_q   <= new_tag;
            valid_q <= 1'b0;
            pend_q  <= 1'b1;
        end else if (take_way && pend_q) begin
            way_q   <= new_way;
            valid_q <= 1'b1;
            pend_q  <= 1'b0;
        end else if (drop_pend) begin
            pend_q  <= 1'b0;
        end
    end
endmodule

// File: rtl/wf_match.sv
// Module: parallel compare of one key against every stored tag, with
// a per-entry enable, plus index and way encoding of the match.
// Assumes: at most one enabled entry matches (duplicates are prevented
// by the allocate path), so OR-encoding is exact.
module wf_match #(
    parameter int DEPTH = 16,
    parameter int TAG_W = 27,
    parameter int WAY_W = 5,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [TAG_W-1:0]             key,
    input  logic [DEPTH-1:0][TAG_W-1:0]  tags,
    input  logic [DEPTH-1:0][WAY_W-1:0]  ways,
    input  logic [DEPTH-1:0]             enable,
    output logic [DEPTH-1:0]             match,
    output logic                         any,
    output logic [IDX_W-1:0]             idx,
    output logic [WAY_W-1:0]             way
);
    // Per-entry comparators.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = enable[i] && (tags[i] == key);
    end

    // OR-encode the matching index and way.
    always_comb begin
        idx = '0;
        way = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                idx = idx | IDX_W'(i);
                way = way | ways[i];
            end
        end
    end

    assign any = |match;
endmodule

// File: rtl/wf_ring_ptr.sv
// Module: wrapping slot counter for first-in first-out replacement.
// Assumes: step is a single-cycle pulse per new allocation.
module wf_ring_ptr #(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [IDX_W-1:0] ptr_q
);
    import wf_pkg::*;

    // Advance modulo DEPTH on each step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (step)
            ptr_q <= IDX_W'(ring_next(int'(ptr_q), DEPTH));
    end
endmodule

// File: rtl/way_finder.sv
// Module: fully associative way lookup table in front of a
// set-associative data cache. Lookup is combinational on stored state;
// allocate claims a pending entry, fill later supplies its way.
// Assumes: WAYS >= 2 and a power of two; DEPTH in 2..64.
module way_finder #(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFF = 5,
    parameter int WAYS     = 32,
    parameter int DEPTH    = 16,
    localparam int TAG_W   = ADDR_W - LINE_OFF,
    localparam int WAY_W   = $clog2(WAYS),
    localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              lk_hit,
    output logic [WAY_W-1:0]  lk_way,
    input  logic              alloc_en,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic              fill_en,
    input  logic [WAY_W-1:0]  fill_way
);
    logic [DEPTH-1:0][TAG_W-1:0] tags_q;
    logic [DEPTH-1:0][WAY_W-1:0] ways_q;
    logic [DEPTH-1:0]            valid_q;
    logic [DEPTH-1:0]            pend_q;
    logic [DEPTH-1:0]            lk_match;
    logic [DEPTH-1:0]            al_match;
    logic [IDX_W-1:0]            lk_idx;
    logic [IDX_W-1:0]            al_idx;
    logic [WAY_W-1:0]            al_way_unused;
    logic                        alloc_reuse;
    logic [IDX_W-1:0]            ptr_q;
    logic [IDX_W-1:0]            target;
    logic [TAG_W-1:0]            lk_tag;
    logic [TAG_W-1:0]            al_tag;

    assign lk_tag = lk_addr[ADDR_W-1:LINE_OFF];
    assign al_tag = alloc_addr[ADDR_W-1:LINE_OFF];

    // Lookup search: only filled entries may answer.
    wf_match #(.DEPTH(DEPTH), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_lk (
        .key(lk_tag), .tags(tags_q), .ways(ways_q), .enable(valid_q),
        .match(lk_match), .any(lk_hit), .idx(lk_idx), .way(lk_way)
    );

    // Allocate search: filled or pending entries are reused.
    wf_match #(.DEPTH(DEPTH), .TAG_W(TAG_W), .WAY_W(WAY_W)) u_al (
        .key(al_tag), .tags(tags_q), .ways(ways_q), .enable(valid_q | pend_q),
        .match(al_match), .any(alloc_reuse), .idx(al_idx), .way(al_way_unused)
    );

    wf_ring_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .step(alloc_en && !alloc_reuse), .ptr_q(ptr_q)
    );

    assign target = alloc_reuse ? al_idx : ptr_q;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        wf_slot #(.TAG_W(TAG_W), .WAY_W(WAY_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .take_tag(alloc_en && (target == IDX_W'(i))),
            .new_tag(al_tag),
            .take_way(fill_en),
            .new_way(fill_way),
            .drop_pend(alloc_en),
            .tag_q(tags_q[i]), .way_q(ways_q[i]),
            .valid_q(valid_q[i]), .pend_q(pend_q[i])
        );
    end
endmodule

// File: rtl/way_finder_chk.sv
// Module: property checker for way_finder, attached by bind.
// Assumes: control inputs are known at every edge after reset.
module way_finder_chk #(
    parameter int DEPTH = 16,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             alloc_en,
    input logic             alloc_reuse,
    input logic             fill_en,
    input logic [DEPTH-1:0] valid_q,
    input logic [DEPTH-1:0] pend_q,
    input logic [DEPTH-1:0] lk_match,
    input logic [IDX_W-1:0] ptr_q
);
    a_r9_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0 && pend_q == '0 && ptr_q == '0));

    a_r4_pend_not_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_q & pend_q) == '0);

    a_r8_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    a_r10_one_pending: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_q));

    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && !alloc_reuse) |=>
            ptr_q == (($past(ptr_q) == IDX_W'(DEPTH - 1)) ? '0 : $past(ptr_q) + 1'b1));

    a_r6_reuse_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_en && alloc_reuse) |=> $stable(ptr_q));

    a_r5_fill_validates: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !alloc_en && pend_q != '0) |=>
            ((valid_q & $past(pend_q)) == $past(pend_q)) && pend_q == '0);
endmodule

bind way_finder way_finder_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_reuse(alloc_reuse),
    .fill_en(fill_en), .valid_q(valid_q), .pend_q(pend_q),
    .lk_match(lk_match), .ptr_q(ptr_q)
);

// File: tb/way_finder_test.sv
module way_finder_test;
    localparam int ADDR_W = 32;
    localparam int WAY_W  = 5;
    localparam int DEPTH  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] lk_addr = '0;
    logic              lk_hit;
    logic [WAY_W-1:0]  lk_way;
    logic              alloc_en = 1'b0;
    logic [ADDR_W-1:0] alloc_addr = '0;
    logic              fill_en = 1'b0;
    logic [WAY_W-1:0]  fill_way = '0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    way_finder uut (
        .clk(clk), .rst_n(rst_n), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_way(lk_way),
        .alloc_en(alloc_en), .alloc_addr(alloc_addr), .fill_en(fill_en), .fill_way(fill_way)
    );

    function automatic logic [ADDR_W-1:0] line_l(input int i);
        return 32'h1000_0000 + 32'(i) * 32;
    endfunction
    function automatic logic [ADDR_W-1:0] line_n(input int j);
        return 32'h2000_0000 + 32'(j) * 64;
    endfunction
    function automatic logic [WAY_W-1:0] way_l(input int i);
        return WAY_W'((i * 5 + 3) % 32);
    endfunction

    task automatic look(input logic [ADDR_W-1:0] a, input logic eh,
                        input logic [WAY_W-1:0] ew, input string req);
        @(negedge clk);
        lk_addr = a;
        #1;
        checks++;
        if (lk_hit !== eh || lk_way !== (eh ? ew : '0)) begin
            errors++;
            $display("FAIL %s addr=%h hit=%b way=%0d expected hit=%b way=%0d",
                     req, a, lk_hit, lk_way, eh, eh ? ew : '0);
        end
    endtask

    task automatic do_alloc(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        alloc_en = 1'b1; alloc_addr = a;
        @(negedge clk);
        alloc_en = 1'b0;
    endtask

    task automatic do_fill(input logic [WAY_W-1:0] w);
        @(negedge clk);
        fill_en = 1'b1; fill_way = w;
        @(negedge clk);
        fill_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9 / R3: empty table after reset
        look(line_l(0), 1'b0, '0, "R9");
        look(line_l(7) + 9, 1'b0, '0, "R3");

        // R4, R1, R7: fill all slots in order
        for (int i = 0; i < DEPTH; i++) begin
            do_alloc(line_l(i) + 32'(i % 32));
            look(line_l(i), 1'b0, '0, "R4");
            do_fill(way_l(i));
            look(line_l(i), 1'b1, way_l(i), "R1");
        end
        // R2: every offset of line 0, and one offset per line
        for (int k = 0; k < 32; k++) look(line_l(0) + 32'(k), 1'b1, way_l(0), "R2");
        for (int i = 0; i < DEPTH; i++) look(line_l(i) + 32'(31 - i), 1'b1, way_l(i), "R2");

        // R6: reallocate a present line, pending hides it, no slot consumed
        do_alloc(line_l(5) + 3);
        look(line_l(5), 1'b0, '0, "R4");
        do_fill(5'd30);
        look(line_l(5), 1'b1, 5'd30, "R6");
        look(line_l(0), 1'b1, way_l(0), "R6");
        look(line_l(15), 1'b1, way_l(15), "R8");

        // R7: sixteen new lines displace the old ones oldest first
        for (int j = 0; j < DEPTH; j++) begin
            do_alloc(line_n(j));
            look(line_n(j), 1'b0, '0, "R4");
            do_fill(WAY_W'(j));
            look(line_n(j), 1'b1, WAY_W'(j), "R7");
            look(line_l(j), 1'b0, '0, "R7");
            if (j < DEPTH - 1)
                look(line_l(j + 1), 1'b1, (j + 1 == 5) ? 5'd30 : way_l(j + 1), "R7");
        end

        // R5: fill with nothing pending changes nothing
        do_fill(5'd7);
        look(line_n(0), 1'b1, 5'd0, "R5");
        look(line_n(15), 1'b1, 5'd15, "R5");

        // R10: second allocation abandons the first
        do_alloc(32'h3000_0000);
        do_alloc(32'h3000_0040);
        do_fill(5'd9);
        look(32'h3000_0040, 1'b1, 5'd9, "R10");
        look(32'h3000_0000, 1'b0, '0, "R10");
        look(line_n(0), 1'b0, '0, "R7");
        look(line_n(2), 1'b1, 5'd2, "R7");

        // R10: fill and allocate in the same cycle
        do_alloc(32'h4000_0000);
        @(negedge clk);
        fill_en = 1'b1; fill_way = 5'd21;
        alloc_en = 1'b1; alloc_addr = 32'h4000_0080;
        @(negedge clk);
        fill_en = 1'b0; alloc_en = 1'b0;
        look(32'h4000_0000, 1'b1, 5'd21, "R10");
        look(32'h4000_0080, 1'b0, '0, "R10");
        do_fill(5'd4);
        look(32'h4000_0080, 1'b1, 5'd4, "R10");

        // R9: reset mid-run clears the table
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        look(line_n(2), 1'b0, '0, "R9");
        look(32'h4000_0080, 1'b0, '0, "R9");

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule